// File: doc/BRIEF.md
# Clocked Memory Port with Selectable Write Output

This block is a single-clock, single-port synchronous memory that can be inferred as an FPGA block RAM. When the port is enabled, one rising clock edge captures the address, the write data and the write-enable together. On that same edge the block performs the read or the write and loads the registered data output. There is no extra pipeline cycle between the edge and the output. There is also no combinational read path: the output changes only on a clock edge.

A 2-bit `wmode` input selects what the output register loads during a write. It can load the word that was stored before the write (read-first), the word being written (write-first), or nothing, so the output keeps its previous value (no-change). A parameter can instead fix the write behaviour at build time. In that case the `wmode` pin is ignored.

Top module: `bram_port`

## Requirements
- R1: While `rst` is high at a rising edge, `rdata` becomes zero after that edge. Reset does not alter the stored words.
- R2: With `en`=1 and `wr`=0 at a rising edge, `rdata` shows the word stored at `addr` right after that same edge. The latency is one edge.
- R3: With `en`=1 and `wr`=1 at a rising edge, `wdata` is stored at `addr`. A later read of that address returns it.
- R4: With `wmode`=2'b00 (read-first), a write loads `rdata` with the word that was stored at `addr` before the write.
- R5: With `wmode`=2'b01 (write-first), a write loads `rdata` with `wdata`.
- R6: With `wmode`=2'b10 (no-change), a write leaves `rdata` at its previous value.
- R7: The code `wmode`=2'b11 behaves exactly like read-first.
- R8: With `en`=0, nothing is written and `rdata` holds its value, whatever `wr`, `addr`, `wdata` and `wmode` are.
- R9: Every word reads as zero before it is first written.
- R10: Back-to-back read-first writes to one address each return the value written by the write before them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all activity on the rising edge |
| rst | input | 1 | Synchronous active-high reset of the output register |
| en | input | 1 | Port enable; when low the port is idle |
| wr | input | 1 | 1 = write cycle, 0 = read cycle |
| addr | input | ADDR_W | Word address |
| wdata | input | DATA_W | Data to store |
| wmode | input | 2 | Output during write: 00 read-first, 01 write-first, 10 no-change, 11 read-first |
| rdata | output | DATA_W | Registered read data |

## Verification
The hardest case to bring about is a write whose output depends on the word being overwritten at that same edge. The clearest instance is a chain of read-first writes to a single address, where each output must be the value from the previous edge and not the one arriving now. The stimulus table places several such writes back to back. It also follows no-change writes with a read of the same word, which shows that the store happened even though the output did not move. A disabled cycle that carries a write request is followed by a read, so that a forbidden write would become visible at the port.

// File: rtl/bram_pkg.sv
package bram_pkg;
  typedef enum logic [1:0] {
    WM_READ_FIRST  = 2'b00,
    WM_WRITE_FIRST = 2'b01,
    WM_NO_CHANGE   = 2'b10,
    WM_ALIAS_RF    = 2'b11
  } wmode_e;

  typedef enum logic [1:0] {
    SEL_OLD  = 2'b00,
    SEL_NEW  = 2'b01,
    SEL_HOLD = 2'b10
  } out_sel_e;
endpackage

// File: rtl/bram_mode_dec.sv
module bram_mode_dec
  import bram_pkg::*;
(
  input  logic       wr,
  input  logic [1:0] wmode,
  output out_sel_e   sel
);
  always_comb begin
    if (!wr) begin
      sel = SEL_OLD;
    end else begin
      unique case (wmode)
        WM_WRITE_FIRST: sel = SEL_NEW;
        WM_NO_CHANGE:   sel = SEL_HOLD;
        default:        sel = SEL_OLD;
      endcase
    end
  end
endmodule

// File: rtl/bram_core.sv
module bram_core
  import bram_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  out_sel_e          sel,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = '0;
  end

  // storage write; independent of reset so the array maps to block RAM
  always_ff @(posedge clk) begin
    if (en && wr) mem[addr] <= wdata;
  end

  // output register, loaded in the same edge as the access
  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (en) begin
      unique case (sel)
        SEL_NEW:  rdata <= wdata;
        SEL_HOLD: rdata <= rdata;
        default:  rdata <= mem[addr];
      endcase
    end
  end
endmodule

// File: rtl/bram_port.sv
module bram_port
  import bram_pkg::*;
#(
  parameter int         DATA_W         = 8,
  parameter int         ADDR_W         = 4,
  parameter bit         MODE_FROM_PORT = 1'b1,
  parameter logic [1:0] FIXED_MODE     = 2'b00
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [1:0]        wmode,
  output logic [DATA_W-1:0] rdata
);
  logic [1:0] mode_eff;
  out_sel_e   sel;

  generate
    if (MODE_FROM_PORT) begin : g_port_mode
      assign mode_eff = wmode;
    end else begin : g_fixed_mode
      assign mode_eff = FIXED_MODE;
    end
  endgenerate

  bram_mode_dec u_dec (
    .wr    (wr),
    .wmode (mode_eff),
    .sel   (sel)
  );

  bram_core #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W)
  ) u_core (
    .clk   (clk),
    .rst   (rst),
    .en    (en),
    .wr    (wr),
    .addr  (addr),
    .wdata (wdata),
    .sel   (sel),
    .rdata (rdata)
  );
endmodule

// File: rtl/bram_port_chk.sv
module bram_port_chk #(
  parameter int         DATA_W         = 8,
  parameter int         ADDR_W         = 4,
  parameter bit         MODE_FROM_PORT = 1'b1,
  parameter logic [1:0] FIXED_MODE     = 2'b00
) (
  input logic              clk,
  input logic              rst,
  input logic              en,
  input logic              wr,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wdata,
  input logic [1:0]        wmode,
  input logic [DATA_W-1:0] rdata
);
  logic [1:0] m;
  assign m = MODE_FROM_PORT ? wmode : FIXED_MODE;

  // R1
  reset_clears_chk: assert property (@(posedge clk) rst |=> rdata == '0);

  // R5
  write_first_chk: assert property (@(posedge clk) disable iff (rst)
    (en && wr && m == 2'b01) |=> rdata == $past(wdata));

  // R6
  no_change_chk: assert property (@(posedge clk) disable iff (rst)
    (en && wr && m == 2'b10) |=> $stable(rdata));

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(rdata));

  // R3
  read_after_write_chk: assert property (@(posedge clk) disable iff (rst)
    (en && !wr && $past(en && wr && !rst) && addr == $past(addr))
      |=> rdata == $past(wdata, 2));
endmodule

bind bram_port bram_port_chk #(
  .DATA_W         (DATA_W),
  .ADDR_W         (ADDR_W),
  .MODE_FROM_PORT (MODE_FROM_PORT),
  .FIXED_MODE     (FIXED_MODE)
) u_chk (.*);

// File: tb/sim_bram_port.sv
module sim_bram_port;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 8;
  localparam int AW = 4;
  localparam int NV = 16;

  typedef struct packed {
    logic          en;
    logic          wr;
    logic [AW-1:0] addr;
    logic [DW-1:0] wdata;
    logic [1:0]    wmode;
  } vec_t;

  // R9 R4 R10 R5 R6 R7 R8 R2 coverage in one walk
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b0, 4'd3, 8'h00, 2'b00},
    '{1'b1, 1'b1, 4'd3, 8'hA5, 2'b00},
    '{1'b1, 1'b0, 4'd3, 8'h00, 2'b00},
    '{1'b1, 1'b1, 4'd3, 8'h5A, 2'b00},
    '{1'b1, 1'b1, 4'd3, 8'hC3, 2'b00},
    '{1'b1, 1'b1, 4'd7, 8'h11, 2'b01},
    '{1'b1, 1'b1, 4'd7, 8'h22, 2'b01},
    '{1'b1, 1'b1, 4'd9, 8'h33, 2'b10},
    '{1'b1, 1'b0, 4'd9, 8'h00, 2'b10},
    '{1'b1, 1'b1, 4'd9, 8'h44, 2'b11},
    '{1'b0, 1'b1, 4'd9, 8'hFF, 2'b00},
    '{1'b1, 1'b0, 4'd9, 8'h00, 2'b00},
    '{1'b1, 1'b1, 4'd2, 8'h66, 2'b10},
    '{1'b1, 1'b1, 4'd2, 8'h77, 2'b10},
    '{1'b1, 1'b0, 4'd2, 8'h00, 2'b01},
    '{1'b0, 1'b0, 4'd3, 8'h00, 2'b00}
  };

  logic          clk = 1'b0;
  logic          rst;
  logic          en;
  logic          wr;
  logic [AW-1:0] addr;
  logic [DW-1:0] wdata;
  logic [1:0]    wmode;
  logic [DW-1:0] rdata;

  logic [DW-1:0] ref_mem [1<<AW];
  logic [DW-1:0] ref_out;
  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bram_port #(.DATA_W(DW), .ADDR_W(AW)) u0 (
    .clk(clk), .rst(rst), .en(en), .wr(wr), .addr(addr),
    .wdata(wdata), .wmode(wmode), .rdata(rdata)
  );

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: rdata=%h expected=%h", tag, act, exp);
    end
  endtask

  // one access: drive at negedge, model the edge, sample 1 unit after it
  task automatic step(input vec_t v, input string tag);
    @(negedge clk);
    en = v.en; wr = v.wr; addr = v.addr; wdata = v.wdata; wmode = v.wmode;
    if (v.en) begin
      if (!v.wr || v.wmode == 2'b00 || v.wmode == 2'b11) ref_out = ref_mem[v.addr];
      else if (v.wmode == 2'b01) ref_out = v.wdata;
      if (v.wr) ref_mem[v.addr] = v.wdata;
    end
    @(posedge clk);
    #1;
    chk(tag, rdata, ref_out);
  endtask

  function automatic string tag_of(vec_t v);
    if (!v.en) return "R8";
    if (!v.wr) return "R2";
    case (v.wmode)
      2'b01:   return "R5";
      2'b10:   return "R6";
      2'b11:   return "R7";
      default: return "R4";
    endcase
  endfunction

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < (1<<AW); i++) ref_mem[i] = '0;
    ref_out = '0;
    rst = 1'b1; en = 1'b0; wr = 1'b0; addr = '0; wdata = '0; wmode = 2'b00;
    repeat (2) @(posedge clk);
    #1;
    chk("R1 reset", rdata, '0);
    @(negedge clk);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) step(VECS[i], tag_of(VECS[i]));

    // R9: untouched word reads zero
    step('{1'b1, 1'b0, 4'd15, 8'h00, 2'b00}, "R9");
    // R3: write then read back
    step('{1'b1, 1'b1, 4'd12, 8'h9C, 2'b01}, "R5");
    step('{1'b1, 1'b0, 4'd12, 8'h00, 2'b00}, "R3");
    // R10: chain of read-first writes
    step('{1'b1, 1'b1, 4'd5, 8'h01, 2'b00}, "R10");
    step('{1'b1, 1'b1, 4'd5, 8'h02, 2'b00}, "R10");
    step('{1'b1, 1'b1, 4'd5, 8'h03, 2'b11}, "R10");
    // R8: disabled write request must not store
    step('{1'b0, 1'b1, 4'd5, 8'hEE, 2'b01}, "R8");
    step('{1'b1, 1'b0, 4'd5, 8'h00, 2'b00}, "R8 no store");

    // R1: reset clears output but keeps contents
    @(negedge clk);
    rst = 1'b1; en = 1'b0;
    @(posedge clk);
    #1;
    ref_out = '0;
    chk("R1 reset mid-run", rdata, '0);
    @(negedge clk);
    rst = 1'b0;
    step('{1'b1, 1'b0, 4'd12, 8'h00, 2'b00}, "R1 contents kept");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule